// File: doc/BRIEF.md
# Serial Pixel Input Port with Transfer Latch

This block forms the write side of a sequential-access video field store. Twelve-bit pixels enter one at a time. They are clocked into a sixteen-deep chain of stages on each rising edge of a pixel shift strobe. A separate transfer strobe copies the whole chain into a holding latch on its falling edge. Because the latch holds its own copy, the pixel stream can keep running while the latched word waits for the storage array.

On a rising edge of the memory-cycle strobe, the block issues a one-cycle write enable, but only when the two-bit transfer mode selects a write. With that enable it presents the latched word as a 192-bit parallel bus, together with the row and column address that were already set up. All strobes are plain inputs. They are sampled in the single system clock domain, and their edges are detected there. The address loader and the array itself sit outside the block.

Top module: `sip_top`

## Requirements
- R1: A rising edge of `shift_clk` shifts `pix_in` into the chain. After a transfer, the oldest retained sample sits in lane 0 (`wr_data[11:0]`) and the newest sits in lane 15 (`wr_data[191:180]`). Lane k occupies bits `[12k+11:12k]`.
- R2: When more than sixteen shift edges arrive between transfers, only the most recent sixteen samples are kept.
- R3: A falling edge of `xfer_stb` copies the entire chain into the holding latch. The latch then keeps that value while further shifting goes on.
- R4: A write is issued only when `mode` is 2'b10 (bit 1 set, bit 0 clear) at the strobe edge. The codes 2'b00, 2'b01 and 2'b11 produce no `wr_en` and leave the write outputs unchanged.
- R5: A rising edge of `mem_stb` with the write code drives `wr_en` high in the next cycle. In that cycle `wr_data` carries the latch contents, and `wr_row`/`wr_col` carry `row_in`/`col_in`, all sampled at that edge.
- R6: When a shift edge and a transfer edge fall on the same clock, the latch receives the chain as it stood before that shift. The new sample still enters the chain.
- R7: `wr_en` lasts exactly one cycle per rising edge of `mem_stb`, even while the strobe stays high. `wr_data`, `wr_row` and `wr_col` hold their values between writes.
- R8: Synchronous active-high `rst` clears the chain, the latch, `wr_en` and the write outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Pixel shift strobe, acts on its rising edge |
| pix_in | input | 12 | Pixel sample |
| xfer_stb | input | 1 | Chain-to-latch transfer strobe, acts on its falling edge |
| mem_stb | input | 1 | Memory-cycle strobe, acts on its rising edge |
| mode | input | 2 | Transfer mode code; 2'b10 selects write |
| row_in | input | 8 | Pre-latched row address |
| col_in | input | 6 | Pre-latched column address |
| wr_en | output | 1 | One-cycle array write enable |
| wr_row | output | 8 | Row address of the write |
| wr_col | output | 6 | Column address of the write |
| wr_data | output | 192 | Sixteen 12-bit lanes, lane 0 lowest |

## Verification
The bench checks lane order after exactly sixteen samples and again after twenty. A design with reversed order would show pixel 15 in the lowest lane, and one without overflow discard would leak the first four samples. It streams new pixels after a transfer but before the write, and fires a transfer and a shift on the same clock. A latch that follows the chain, or one that captures post-shift data, would return the wrong word. It also holds the memory strobe high for several cycles, tries each non-write mode code, and resets with a full latch. These catch level-triggered writes, a decoder that accepts the wrong code, and a latch or output register that survives reset.

// File: rtl/sip_pkg.sv
package sip_pkg;

    localparam int LANES  = 16;
    localparam int PIX_W  = 12;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 6;
    localparam int WORD_W = LANES * PIX_W;

    typedef logic [PIX_W-1:0] pix_t;
    typedef pix_t [LANES-1:0] lanes_t;   // lane 0 in the lowest bits

    typedef enum logic [1:0] {
        XM_NOP0  = 2'b00,
        XM_NOP1  = 2'b01,
        XM_WRITE = 2'b10,
        XM_NOP3  = 2'b11
    } xmode_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        lanes_t           data;
    } wr_req_t;

    function automatic logic mode_is_write(input logic [1:0] m);
        return xmode_e'(m) == XM_WRITE;
    endfunction

endpackage

// File: rtl/sip_edge_det.sv
module sip_edge_det #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic sig,
    output logic edge_o
);
    logic prev;

    // The previous value simply follows the input, so no edge is seen out of reset.
    always_ff @(posedge clk) begin
        prev <= sig;
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = sig & ~prev;
        end else begin : g_fall
            assign edge_o = ~sig & prev;
        end
    endgenerate
endmodule

// File: rtl/sip_shift_chain.sv
module sip_shift_chain #(
    parameter int LANES = 16,
    parameter int PIX_W = 12,
    localparam int WORD_W = LANES * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [PIX_W-1:0]  din,
    output logic [WORD_W-1:0] word_o
);
    logic [PIX_W-1:0] stage [LANES];

    // The newest sample enters the top stage and older samples move toward stage 0.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_stage
            if (i == LANES - 1) begin : g_top
                always_ff @(posedge clk) begin
                    if (rst)           stage[i] <= '0;
                    else if (shift_en) stage[i] <= din;
                end
            end else begin : g_mid
                always_ff @(posedge clk) begin
                    if (rst)           stage[i] <= '0;
                    else if (shift_en) stage[i] <= stage[i+1];
                end
            end
            assign word_o[i*PIX_W +: PIX_W] = stage[i];
        end
    endgenerate
endmodule

// File: rtl/sip_hold_latch.sv
module sip_hold_latch #(
    parameter int W = 192
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/sip_write_port.sv
module sip_write_port
    import sip_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [1:0]       mode,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    input  lanes_t           data_in,
    output logic             wr_en,
    output wr_req_t          req_o
);
    logic    go;
    wr_req_t nxt;

    always_comb begin
        go       = fire && mode_is_write(mode);
        nxt.row  = row_in;
        nxt.col  = col_in;
        nxt.data = data_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en <= 1'b0;
            req_o <= '0;
        end else begin
            wr_en <= go;
            if (go) req_o <= nxt;
        end
    end
endmodule

// File: rtl/sip_top.sv
module sip_top
    import sip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_clk,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              xfer_stb,
    input  logic              mem_stb,
    input  logic [1:0]        mode,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    output logic              wr_en,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [WORD_W-1:0] wr_data
);
    logic              shift_edge, xfer_edge, mem_edge;
    logic [WORD_W-1:0] chain_word;
    logic [WORD_W-1:0] latch_word;
    wr_req_t           req;

    sip_edge_det #(.RISE(1'b1)) u_shift_edge (.clk(clk), .sig(shift_clk), .edge_o(shift_edge));
    sip_edge_det #(.RISE(1'b0)) u_xfer_edge  (.clk(clk), .sig(xfer_stb),  .edge_o(xfer_edge));
    sip_edge_det #(.RISE(1'b1)) u_mem_edge   (.clk(clk), .sig(mem_stb),   .edge_o(mem_edge));

    sip_shift_chain #(.LANES(LANES), .PIX_W(PIX_W)) u_chain (
        .clk(clk), .rst(rst), .shift_en(shift_edge), .din(pix_in), .word_o(chain_word)
    );

    // The latch samples the registered chain, so a concurrent shift is not seen.
    sip_hold_latch #(.W(WORD_W)) u_latch (
        .clk(clk), .rst(rst), .load(xfer_edge), .d(chain_word), .q(latch_word)
    );

    sip_write_port u_wport (
        .clk(clk), .rst(rst), .fire(mem_edge), .mode(mode),
        .row_in(row_in), .col_in(col_in), .data_in(lanes_t'(latch_word)),
        .wr_en(wr_en), .req_o(req)
    );

    assign wr_row  = req.row;
    assign wr_col  = req.col;
    assign wr_data = req.data;
endmodule

// File: rtl/sip_top_chk.sv
module sip_top_chk
    import sip_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              xfer_stb,
    input logic              mem_stb,
    input logic [1:0]        mode,
    input logic              wr_en,
    input logic [ROW_W-1:0]  wr_row,
    input logic [COL_W-1:0]  wr_col,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] latch_q
);
    AST_WE_MODE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(mode) == 2'b10);                          // R4

    AST_WE_STROBE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(mem_stb));                                 // R5

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);                                         // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> ($stable(wr_data) && $stable(wr_row) && $stable(wr_col))); // R7

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !($past(xfer_stb) && !xfer_stb) |=> $stable(latch_q));     // R3

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!wr_en && wr_data == '0 && latch_q == '0));       // R8
endmodule

bind sip_top sip_top_chk u_chk (
    .clk(clk), .rst(rst), .xfer_stb(xfer_stb), .mem_stb(mem_stb), .mode(mode),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .latch_q(latch_word)
);

// File: tb/tb_sip_top.sv
`timescale 1ns/1ps
module tb_sip_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shift_clk = 1'b0;
    logic [11:0]  pix_in = '0;
    logic         xfer_stb = 1'b1;
    logic         mem_stb = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [7:0]   row_in = '0;
    logic [5:0]   col_in = '0;
    logic         wr_en;
    logic [7:0]   wr_row;
    logic [5:0]   wr_col;
    logic [191:0] wr_data;

    int checks = 0;
    int errors = 0;
    int writes_seen = 0;

    logic [11:0]  m_sh [16];
    logic [191:0] m_lat = '0;
    logic [205:0] exp_q [$];   // {row, col, data}

    sip_top dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [191:0] pack_sh();
        logic [191:0] w;
        for (int i = 0; i < 16; i++) w[i*12 +: 12] = m_sh[i];
        return w;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic shift_pix(input logic [11:0] v);
        pix_in = v; shift_clk = 1'b1; tick();
        for (int i = 0; i < 15; i++) m_sh[i] = m_sh[i+1];
        m_sh[15] = v;
        shift_clk = 1'b0; tick();
    endtask

    task automatic do_xfer();
        xfer_stb = 1'b0; tick();
        m_lat = pack_sh();
        xfer_stb = 1'b1; tick();
    endtask

    task automatic do_write(input logic [1:0] m, input logic [7:0] r, input logic [5:0] c, input int hold);
        mode = m; row_in = r; col_in = c; mem_stb = 1'b1;
        if (m == 2'b10) exp_q.push_back({r, c, m_lat});
        for (int i = 0; i < hold; i++) tick();
        mem_stb = 1'b0; tick();
        tick();
    endtask

    // Monitor: pops expected writes as wr_en pulses appear.
    logic last_we = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en && last_we) chk(1'b0, "R7 wr_en longer than one cycle", 192'(wr_en), 192'(0));
            if (wr_en) begin
                writes_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", wr_data, 192'(0));
                end else begin
                    logic [205:0] e;
                    e = exp_q.pop_front();
                    chk(wr_data == e[191:0], "R1/R2/R3/R6 write data", wr_data, e[191:0]);
                    chk({wr_row, wr_col} == e[205:192], "R5 write address",
                        192'({wr_row, wr_col}), 192'(e[205:192]));
                end
            end
        end
        last_we = wr_en;
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 192'(0), 192'(1));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        logic [191:0] held;
        for (int i = 0; i < 16; i++) m_sh[i] = '0;
        tick(); tick(); tick();
        rst = 1'b0; tick();

        // R8: reset state
        chk(wr_en == 1'b0, "R8 wr_en after reset", 192'(wr_en), 192'(0));
        chk(wr_data == '0, "R8 wr_data after reset", wr_data, 192'(0));

        // R1, R5: exactly sixteen samples, lane order
        for (int i = 0; i < 16; i++) shift_pix(12'h100 + 12'(i));
        do_xfer();
        base = writes_seen;
        do_write(2'b10, 8'h21, 6'h05, 1);
        chk(writes_seen == base + 1, "R5 one write issued", 192'(writes_seen), 192'(base + 1));
        chk(wr_data[11:0] == 12'h100, "R1 lane 0 oldest", 192'(wr_data[11:0]), 192'(12'h100));
        chk(wr_data[191:180] == 12'h10F, "R1 lane 15 newest", 192'(wr_data[191:180]), 192'(12'h10F));

        // R2: twenty samples, first four dropped
        for (int i = 0; i < 20; i++) shift_pix(12'hA00 + 12'(i * 3));
        do_xfer();
        do_write(2'b10, 8'hC3, 6'h3F, 1);
        chk(wr_data[11:0] == 12'hA00 + 12'(12), "R2 oldest kept is sample 4", 192'(wr_data[11:0]), 192'(12'hA0C));

        // R3: shifting after transfer does not disturb the latch
        held = m_lat;
        for (int i = 0; i < 16; i++) shift_pix(12'h5A0 ^ 12'(i));
        do_write(2'b10, 8'h07, 6'h11, 1);
        chk(wr_data == held, "R3 latch held while streaming", wr_data, held);

        // R4: non-write codes ignored
        do_xfer();
        held = wr_data;
        base = writes_seen;
        do_write(2'b00, 8'hEE, 6'h2A, 1);
        do_write(2'b01, 8'hEE, 6'h2A, 1);
        do_write(2'b11, 8'hEE, 6'h2A, 1);
        chk(writes_seen == base, "R4 no write for codes 00/01/11", 192'(writes_seen), 192'(base));
        chk(wr_data == held, "R4 outputs unchanged", wr_data, held);
        chk(wr_row != 8'hEE, "R4 row unchanged", 192'(wr_row), 192'(8'h07));
        do_write(2'b10, 8'h44, 6'h22, 1);

        // R6: shift and transfer on the same clock
        shift_pix(12'h0F1);
        pix_in = 12'hBEE; shift_clk = 1'b1; xfer_stb = 1'b0; tick();
        m_lat = pack_sh();
        for (int i = 0; i < 15; i++) m_sh[i] = m_sh[i+1];
        m_sh[15] = 12'hBEE;
        shift_clk = 1'b0; xfer_stb = 1'b1; tick();
        do_write(2'b10, 8'h66, 6'h01, 1);
        chk(wr_data[191:180] == 12'h0F1, "R6 latch saw pre-shift chain", 192'(wr_data[191:180]), 192'(12'h0F1));
        do_xfer();
        do_write(2'b10, 8'h67, 6'h02, 1);
        chk(wr_data[191:180] == 12'hBEE, "R6 concurrent sample entered chain", 192'(wr_data[191:180]), 192'(12'hBEE));

        // R7: strobe held high gives one pulse
        base = writes_seen;
        do_write(2'b10, 8'h99, 6'h09, 5);
        chk(writes_seen == base + 1, "R7 single pulse on long strobe", 192'(writes_seen), 192'(base + 1));

        // R8: reset clears chain and latch
        rst = 1'b1; tick(); tick();
        rst = 1'b0; tick();
        for (int i = 0; i < 16; i++) m_sh[i] = '0;
        m_lat = '0;
        chk(wr_data == '0 && wr_en == 1'b0, "R8 outputs cleared", wr_data, 192'(0));
        do_write(2'b10, 8'h12, 6'h34, 1);
        chk(wr_data == '0, "R8 latch cleared", wr_data, 192'(0));
        do_xfer();
        do_write(2'b10, 8'h13, 6'h35, 1);
        chk(wr_data == '0, "R8 chain cleared", wr_data, 192'(0));

        tick(); tick();
        chk(exp_q.size() == 0, "R5 all expected writes seen", 192'(exp_q.size()), 192'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule